// File: doc/BRIEF.md
# Dual-Path Vectored Interrupt Controller

This block gathers a parameterised set of interrupt request lines (64 by default) and presents them to a processor as two request outputs: a normal request (`irq_o`) and a fast request (`fiq_o`). Each line carries its own enable bit and its own path select, so software decides line by line which output a line may raise. The lowest-numbered lines (20 by default) are treated as external pins. They pass through a two-flop synchroniser and can be sensed as high level, low level, rising edge, falling edge or either edge. The remaining internal lines are sampled directly and can only be sensed as high or low level.

For the normal path, a table of prioritised slots binds source numbers to programmable vectors. The vector register returns the vector of the lowest-numbered active slot, or a programmable default when no slot is active. The fast path has two priority levels, each with its own vector. A priority mask word suppresses normal slots at or below a chosen slot index and fast requests at or below a chosen level. Edge-sensed lines set a sticky pending bit, which software clears by writing ones to a clear register. All configuration, status and vector registers sit behind a flat 32-bit register port: writes are synchronous and reads are combinational.

Top module: `vic_dual`

## Requirements
- R1: A source raises `irq_o` only when its enable bit (config bit 0) is 1 and its path bit (config bit 1) is 0. It raises `fiq_o` only when both bits are 1. A disabled source raises neither output. Source config words sit at address 0x40 plus the source number.
- R2: An internal source (number >= 20) uses config bit 4 as its polarity: 0 is active high, 1 is active low. Config bits 6:5 of an internal source are discarded and read back as 0.
- R3: External sources use config bits 6:4 as the sense code: 0 high level, 1 low level, 2 rising edge, 3 falling edge, 4 either edge, and 5 to 7 behave as high level. After an external pin changes, a level-sensed source reaches the output at the third rising clock edge and an edge-sensed source at the fourth.
- R4: An edge event sets a pending bit that holds until a 1 is written to its bit in the clear words (0x04 for sources 0-31, 0x05 for sources 32-63). Selecting a level sense code drops the pending bit.
- R5: `irq_o` and `fiq_o` are registered. Each is high in the cycle after at least one enabled, unmasked source on its path is active, and low otherwise.
- R6: Slot j (address 0x80+j) holds the source number in bits 5:0, a valid flag in bit 7 and the vector in bits 31:16. Reading 0x06 returns the vector of the lowest-indexed valid slot whose index is below the normal mask and whose source would raise `irq_o`. If there is no such slot, it returns the default vector held at 0x08.
- R7: The mask word at 0x0A holds the normal mask in bits 5:0. A normal-path source is delivered only when it is bound to a valid slot with an index below the mask, or when it is bound to no slot and the mask exceeds 32. The mask resets to 33.
- R8: Config bit 2 sets the fast level of a source: 0 is high, 1 is low. Bits 9:8 of the mask word are the fast mask (reset 2). A high-level source is delivered when the fast mask is at least 1, and a low-level source when it is at least 2. Reading 0x07 returns the high-level vector (0x09 bits 15:0) if any high-level source is delivered, otherwise the low-level vector (0x09 bits 31:16) if any low-level source is delivered, otherwise 0.
- R9: Words 0x00/0x01 return the raw active state of sources 0-31/32-63, regardless of enable or mask. Words 0x02/0x03 return only the sources currently delivered to either output.
- R10: After reset both outputs are low, every source and slot word reads 0, the default and fast vectors read 0, and the mask word reads 0x221.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt request lines; the lowest NUM_EXT are external pins |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational register read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench drives internal lines of both polarities, external pins in every sense code, single-cycle pulses and held levels, and steps through the mask values next to the active slot. A pulse that outlives its input separates edge sensing from level sensing. A mask set just below and just above the bound slot separates the `<` comparison from `<=`. Two bound sources active together show whether the lowest slot index wins. The count of edges to the first high output tells the synchronised path apart from the direct path. A behavioural model that keeps its own pending state and searches the slots linearly is compared against both request outputs on every clock.

// File: rtl/vic_pkg.sv
package vic_pkg;
   typedef enum logic [2:0] {
      SNS_HIGH = 3'd0,
      SNS_LOW  = 3'd1,
      SNS_RISE = 3'd2,
      SNS_FALL = 3'd3,
      SNS_BOTH = 3'd4
   } sense_e;

   typedef enum logic [1:0] {
      PG_GLOB = 2'd0,
      PG_SRC  = 2'd1,
      PG_SLOT = 2'd2,
      PG_RSVD = 2'd3
   } page_e;

   localparam logic [5:0] A_RAW0 = 6'd0;
   localparam logic [5:0] A_RAW1 = 6'd1;
   localparam logic [5:0] A_MSK0 = 6'd2;
   localparam logic [5:0] A_MSK1 = 6'd3;
   localparam logic [5:0] A_CLR0 = 6'd4;
   localparam logic [5:0] A_CLR1 = 6'd5;
   localparam logic [5:0] A_IVEC = 6'd6;
   localparam logic [5:0] A_FVEC = 6'd7;
   localparam logic [5:0] A_IDEF = 6'd8;
   localparam logic [5:0] A_FCFG = 6'd9;
   localparam logic [5:0] A_MASK = 6'd10;
endpackage

// File: rtl/vic_ext_sense.sv
module vic_ext_sense
   import vic_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       src_i,
   input  logic [2:0] mode_i,
   input  logic       clr_i,
   output logic       raw_o
);
   logic meta_q, sync_q, prev_q, pend_q;
   logic edge_mode, evt, pend_nx;

   // two-stage synchroniser plus one history flop for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= 1'b0;
         sync_q <= 1'b0;
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         meta_q <= src_i;
         sync_q <= meta_q;
         prev_q <= sync_q;
         pend_q <= pend_nx;
      end
   end

   always_comb begin
      edge_mode = 1'b1;
      evt       = 1'b0;
      case (sense_e'(mode_i))
         SNS_RISE: evt = sync_q & ~prev_q;
         SNS_FALL: evt = ~sync_q & prev_q;
         SNS_BOTH: evt = sync_q ^ prev_q;
         default:  edge_mode = 1'b0;
      endcase
      pend_nx = edge_mode ? ((pend_q & ~clr_i) | evt) : 1'b0;
      if (edge_mode)                        raw_o = pend_q;
      else if (sense_e'(mode_i) == SNS_LOW) raw_o = ~sync_q;
      else                                  raw_o = sync_q;
   end

   assert_sync_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sync_q |-> $past(src_i, 2));

   assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && edge_mode && !clr_i) |=> pend_q);

   assert_level_nolatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_mode |=> !pend_q);
endmodule

// File: rtl/vic_slot_pick.sv
module vic_slot_pick #(
   parameter int NUM_SLOT = 32,
   parameter int VEC_W    = 16,
   localparam int IDX_W   = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SLOT-1:0] hit_i,
   input  logic [VEC_W-1:0]    vec_i [NUM_SLOT],
   input  logic [VEC_W-1:0]    dflt_i,
   output logic [VEC_W-1:0]    vec_o,
   output logic                found_o,
   output logic [IDX_W-1:0]    idx_o
);
   // descending scan: the last assignment comes from the lowest index
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int j = NUM_SLOT - 1; j >= 0; j--) begin
         if (hit_i[j]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(j);
         end
      end
      vec_o = found_o ? vec_i[idx_o] : dflt_i;
   end

   assert_pick_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      found_o |-> (hit_i[idx_o] && ((hit_i & ~({NUM_SLOT{1'b1}} << idx_o)) == '0)));

   assert_pick_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !found_o |-> (hit_i == '0 && vec_o == dflt_i));
endmodule

// File: rtl/vic_dual.sv
module vic_dual
   import vic_pkg::*;
#(
   parameter int NUM_SRC  = 64,
   parameter int NUM_EXT  = 20,
   parameter int NUM_SLOT = 32,
   parameter int VEC_W    = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               cfg_we,
   input  logic [7:0]         cfg_addr,
   input  logic [31:0]        cfg_wdata,
   output logic [31:0]        cfg_rdata,
   output logic               irq_o,
   output logic               fiq_o
);
   localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int MSK_W = $clog2(NUM_SLOT + 2);
   localparam int IDX_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1;
   localparam logic [MSK_W-1:0] MSK_OPEN = MSK_W'(NUM_SLOT + 1);

   if (NUM_SRC < 1 || NUM_SRC > 64)   begin : g_bad_src  $error("NUM_SRC out of range"); end
   if (NUM_EXT < 0 || NUM_EXT > NUM_SRC) begin : g_bad_ext $error("NUM_EXT out of range"); end
   if (NUM_SLOT < 1 || NUM_SLOT > 64) begin : g_bad_slot $error("NUM_SLOT out of range"); end
   if (VEC_W < 1 || VEC_W > 16)       begin : g_bad_vec  $error("VEC_W out of range"); end

   // ---------------- configuration state ----------------
   logic [NUM_SRC-1:0] en_q, fsel_q, flvl_q;
   logic [2:0]         mode_q     [NUM_SRC];
   logic [SRC_W-1:0]   slot_src_q [NUM_SLOT];
   logic [VEC_W-1:0]   slot_vec_q [NUM_SLOT];
   logic [NUM_SLOT-1:0] slot_val_q;
   logic [VEC_W-1:0]   idef_q, fhi_q, flo_q;
   logic [MSK_W-1:0]   imask_q;
   logic [1:0]         fmask_q;

   page_e      page;
   logic [5:0] widx;
   logic       wr_glob, wr_src, wr_slot;
   logic [63:0] clr_full;

   assign page    = page_e'(cfg_addr[7:6]);
   assign widx    = cfg_addr[5:0];
   assign wr_glob = cfg_we && (page == PG_GLOB);
   assign wr_src  = cfg_we && (page == PG_SRC);
   assign wr_slot = cfg_we && (page == PG_SLOT);

   always_comb begin
      clr_full = '0;
      if (wr_glob && widx == A_CLR0) clr_full[31:0]  = cfg_wdata;
      if (wr_glob && widx == A_CLR1) clr_full[63:32] = cfg_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= '0;
         fsel_q     <= '0;
         flvl_q     <= '0;
         slot_val_q <= '0;
         idef_q     <= '0;
         fhi_q      <= '0;
         flo_q      <= '0;
         imask_q    <= MSK_OPEN;
         fmask_q    <= 2'd2;
         for (int i = 0; i < NUM_SRC; i++)  mode_q[i] <= '0;
         for (int j = 0; j < NUM_SLOT; j++) begin
            slot_src_q[j] <= '0;
            slot_vec_q[j] <= '0;
         end
      end else begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (wr_src && int'(widx) == i) begin
               en_q[i]   <= cfg_wdata[0];
               fsel_q[i] <= cfg_wdata[1];
               flvl_q[i] <= cfg_wdata[2];
               mode_q[i] <= (i < NUM_EXT) ? cfg_wdata[6:4] : {2'b00, cfg_wdata[4]};
            end
         end
         for (int j = 0; j < NUM_SLOT; j++) begin
            if (wr_slot && int'(widx) == j) begin
               slot_src_q[j] <= cfg_wdata[SRC_W-1:0];
               slot_val_q[j] <= cfg_wdata[7];
               slot_vec_q[j] <= cfg_wdata[16 +: VEC_W];
            end
         end
         if (wr_glob && widx == A_IDEF) idef_q <= cfg_wdata[VEC_W-1:0];
         if (wr_glob && widx == A_FCFG) begin
            fhi_q <= cfg_wdata[VEC_W-1:0];
            flo_q <= cfg_wdata[16 +: VEC_W];
         end
         if (wr_glob && widx == A_MASK) begin
            imask_q <= cfg_wdata[MSK_W-1:0];
            fmask_q <= cfg_wdata[9:8];
         end
      end
   end

   // ---------------- per-source sensing ----------------
   logic [NUM_SRC-1:0] raw;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i < NUM_EXT) begin : g_ext
         vic_ext_sense u_sense (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_i[i]),
            .mode_i (mode_q[i]),
            .clr_i  (clr_full[i]),
            .raw_o  (raw[i])
         );
      end else begin : g_int
         assign raw[i] = mode_q[i][0] ? ~src_i[i] : src_i[i];
      end
   end

   // ---------------- routing and masking ----------------
   logic [NUM_SRC-1:0]  irq_el, fiq_el, irq_dl, fiq_dl, bound, bound_ok;
   logic [NUM_SLOT-1:0] slot_hit;
   logic                open_unbound, fhi_ok, flo_ok;

   assign irq_el       = raw & en_q & ~fsel_q;
   assign fiq_el       = raw & en_q & fsel_q;
   assign open_unbound = int'(imask_q) > NUM_SLOT;
   assign fhi_ok       = fmask_q >= 2'd1;
   assign flo_ok       = fmask_q >= 2'd2;

   always_comb begin
      bound    = '0;
      bound_ok = '0;
      slot_hit = '0;
      for (int j = 0; j < NUM_SLOT; j++) begin
         if (slot_val_q[j] && int'(slot_src_q[j]) < NUM_SRC) begin
            bound[slot_src_q[j]] = 1'b1;
            if (j < int'(imask_q)) begin
               bound_ok[slot_src_q[j]] = 1'b1;
               slot_hit[j]             = irq_el[slot_src_q[j]];
            end
         end
      end
   end

   assign irq_dl = irq_el & (bound_ok | (~bound & {NUM_SRC{open_unbound}}));
   assign fiq_dl = fiq_el & ((~flvl_q & {NUM_SRC{fhi_ok}}) | (flvl_q & {NUM_SRC{flo_ok}}));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
         fiq_o <= 1'b0;
      end else begin
         irq_o <= |irq_dl;
         fiq_o <= |fiq_dl;
      end
   end

   // ---------------- vectors ----------------
   logic [VEC_W-1:0] ivec, fvec;
   logic             ivec_found;
   logic [IDX_W-1:0] ivec_idx;

   vic_slot_pick #(.NUM_SLOT(NUM_SLOT), .VEC_W(VEC_W)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (slot_hit),
      .vec_i   (slot_vec_q),
      .dflt_i  (idef_q),
      .vec_o   (ivec),
      .found_o (ivec_found),
      .idx_o   (ivec_idx)
   );

   always_comb begin
      if (|(fiq_dl & ~flvl_q))     fvec = fhi_q;
      else if (|(fiq_dl & flvl_q)) fvec = flo_q;
      else                         fvec = '0;
   end

   // ---------------- read mux ----------------
   logic [63:0] raw64, dl64;
   assign raw64 = 64'(raw);
   assign dl64  = 64'(irq_dl | fiq_dl);

   always_comb begin
      cfg_rdata = '0;
      case (page)
         PG_GLOB: begin
            case (widx)
               A_RAW0: cfg_rdata = raw64[31:0];
               A_RAW1: cfg_rdata = raw64[63:32];
               A_MSK0: cfg_rdata = dl64[31:0];
               A_MSK1: cfg_rdata = dl64[63:32];
               A_IVEC: cfg_rdata[VEC_W-1:0] = ivec;
               A_FVEC: cfg_rdata[VEC_W-1:0] = fvec;
               A_IDEF: cfg_rdata[VEC_W-1:0] = idef_q;
               A_FCFG: begin
                  cfg_rdata[VEC_W-1:0]  = fhi_q;
                  cfg_rdata[16 +: VEC_W] = flo_q;
               end
               A_MASK: begin
                  cfg_rdata[MSK_W-1:0] = imask_q;
                  cfg_rdata[9:8]       = fmask_q;
               end
               default: cfg_rdata = '0;
            endcase
         end
         PG_SRC: begin
            for (int i = 0; i < NUM_SRC; i++) begin
               if (int'(widx) == i) begin
                  cfg_rdata[0]   = en_q[i];
                  cfg_rdata[1]   = fsel_q[i];
                  cfg_rdata[2]   = flvl_q[i];
                  cfg_rdata[6:4] = mode_q[i];
               end
            end
         end
         PG_SLOT: begin
            for (int j = 0; j < NUM_SLOT; j++) begin
               if (int'(widx) == j) begin
                  cfg_rdata[SRC_W-1:0]   = slot_src_q[j];
                  cfg_rdata[7]           = slot_val_q[j];
                  cfg_rdata[16 +: VEC_W] = slot_vec_q[j];
               end
            end
         end
         default: cfg_rdata = '0;
      endcase
   end

   assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(|irq_dl));

   assert_fiq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> $past(|fiq_dl));

   assert_vec_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ivec_found |-> irq_dl[slot_src_q[ivec_idx]]);

   assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |=> !irq_o && !fiq_o);
endmodule

// File: tb/vic_dual_tb.sv
`timescale 1ns/1ps
module vic_dual_tb;
   localparam int NS  = 64;
   localparam int NE  = 20;
   localparam int NSL = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src_i = '0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        irq_o, fiq_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   vic_dual #(.NUM_SRC(NS), .NUM_EXT(NE), .NUM_SLOT(NSL), .VEC_W(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_o(irq_o), .fiq_o(fiq_o));

   // ---------------- behavioural reference ----------------
   bit [63:0] m_en, m_fs, m_fl, m_s1, m_s2, m_pv, m_pd;
   bit [2:0]  m_md [64];
   bit [5:0]  m_ss [32];
   bit        m_sv [32];
   bit [15:0] m_sc [32];
   bit [15:0] m_idef, m_fhi, m_flo;
   int        m_im, m_fm;
   bit        m_irq, m_fiq;

   function automatic bit m_act(int i);
      if (i < NE) begin
         if (m_md[i] >= 2 && m_md[i] <= 4) return m_pd[i];
         if (m_md[i] == 1) return !m_s2[i];
         return m_s2[i];
      end
      return m_md[i][0] ? !src_i[i] : src_i[i];
   endfunction

   function automatic int m_lvl(int i);
      for (int j = 0; j < NSL; j++) if (m_sv[j] && int'(m_ss[j]) == i) return j;
      return NSL;
   endfunction

   function automatic bit m_idl(int i);
      return m_act(i) && m_en[i] && !m_fs[i] && (m_lvl(i) < m_im);
   endfunction

   function automatic bit m_fdl(int i);
      return m_act(i) && m_en[i] && m_fs[i] && (m_fl[i] ? (m_fm >= 2) : (m_fm >= 1));
   endfunction

   function automatic bit [15:0] m_ivec();
      for (int j = 0; j < NSL; j++) begin
         if (m_sv[j] && j < m_im) begin
            int s = int'(m_ss[j]);
            if (m_act(s) && m_en[s] && !m_fs[s]) return m_sc[j];
         end
      end
      return m_idef;
   endfunction

   function automatic bit [15:0] m_fvec();
      bit hi = 0, lo = 0;
      for (int i = 0; i < NS; i++) if (m_fdl(i)) begin
         if (m_fl[i]) lo = 1; else hi = 1;
      end
      if (hi) return m_fhi;
      if (lo) return m_flo;
      return 16'h0;
   endfunction

   function automatic bit [31:0] m_read(bit [7:0] a);
      bit [63:0] r = 0, d = 0;
      int idx = int'(a[5:0]);
      for (int i = 0; i < NS; i++) begin
         r[i] = m_act(i);
         d[i] = m_idl(i) || m_fdl(i);
      end
      if (a[7:6] == 2'd1) return {25'd0, m_md[idx], 1'b0, m_fl[idx], m_fs[idx], m_en[idx]};
      if (a[7:6] == 2'd2) begin
         if (idx >= NSL) return 0;
         return {m_sc[idx], 8'd0, m_sv[idx], 1'b0, m_ss[idx]};
      end
      if (a[7:6] != 2'd0) return 0;
      case (idx)
         0: return r[31:0];
         1: return r[63:32];
         2: return d[31:0];
         3: return d[63:32];
         6: return {16'd0, m_ivec()};
         7: return {16'd0, m_fvec()};
         8: return {16'd0, m_idef};
         9: return {m_flo, m_fhi};
         10: return 32'(m_im) | (32'(m_fm) << 8);
         default: return 0;
      endcase
   endfunction

   task automatic m_reset();
      m_en = 0; m_fs = 0; m_fl = 0; m_s1 = 0; m_s2 = 0; m_pv = 0; m_pd = 0;
      for (int i = 0; i < 64; i++) m_md[i] = 0;
      for (int j = 0; j < 32; j++) begin m_ss[j] = 0; m_sv[j] = 0; m_sc[j] = 0; end
      m_idef = 0; m_fhi = 0; m_flo = 0; m_im = NSL + 1; m_fm = 2;
      m_irq = 0; m_fiq = 0;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_reset();
      else begin
         bit ni, nf, e;
         bit [63:0] c;
         int idx;
         ni = 0; nf = 0; c = 0;
         for (int i = 0; i < NS; i++) begin
            ni |= m_idl(i);
            nf |= m_fdl(i);
         end
         idx = int'(cfg_addr[5:0]);
         if (cfg_we && cfg_addr == 8'h04) c[31:0]  = cfg_wdata;
         if (cfg_we && cfg_addr == 8'h05) c[63:32] = cfg_wdata;
         for (int i = 0; i < NE; i++) begin
            case (m_md[i])
               2: e = m_s2[i] && !m_pv[i];
               3: e = !m_s2[i] && m_pv[i];
               4: e = m_s2[i] != m_pv[i];
               default: e = 0;
            endcase
            if (m_md[i] >= 2 && m_md[i] <= 4) m_pd[i] = (m_pd[i] && !c[i]) || e;
            else m_pd[i] = 0;
         end
         m_pv = m_s2; m_s2 = m_s1; m_s1 = 64'(src_i[NE-1:0]);
         if (cfg_we) begin
            if (cfg_addr[7:6] == 2'd1) begin
               m_en[idx] = cfg_wdata[0]; m_fs[idx] = cfg_wdata[1]; m_fl[idx] = cfg_wdata[2];
               m_md[idx] = (idx < NE) ? cfg_wdata[6:4] : {2'b00, cfg_wdata[4]};
            end else if (cfg_addr[7:6] == 2'd2 && idx < NSL) begin
               m_ss[idx] = cfg_wdata[5:0]; m_sv[idx] = cfg_wdata[7]; m_sc[idx] = cfg_wdata[31:16];
            end else if (cfg_addr == 8'h08) m_idef = cfg_wdata[15:0];
            else if (cfg_addr == 8'h09) begin m_fhi = cfg_wdata[15:0]; m_flo = cfg_wdata[31:16]; end
            else if (cfg_addr == 8'h0A) begin m_im = int'(cfg_wdata[5:0]); m_fm = int'(cfg_wdata[9:8]); end
         end
         m_irq = ni; m_fiq = nf;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n && !done) begin
      chk("R5 irq_o vs model", 32'(irq_o), 32'(m_irq));
      chk("R5 fiq_o vs model", 32'(fiq_o), 32'(m_fiq));
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(bit [7:0] a, bit [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_lit(bit [7:0] a, bit [31:0] exp, string tag);
      @(negedge clk);
      cfg_addr = a;
      #1;
      chk(tag, cfg_rdata, exp);
      chk({tag, " model"}, cfg_rdata, m_read(a));
   endtask

   task automatic pins(bit ei, bit ef, string tag);
      chk({tag, " irq_o"}, 32'(irq_o), 32'(ei));
      chk({tag, " fiq_o"}, 32'(fiq_o), 32'(ef));
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         bad++; total++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R10 reset state
      pins(0, 0, "R10 reset");
      rd_lit(8'h0A, 32'h221, "R10 mask word");
      rd_lit(8'h40, 32'h0, "R10 src cfg");
      rd_lit(8'h80, 32'h0, "R10 slot");
      rd_lit(8'h06, 32'h0, "R10 default vector");

      // R2 internal polarity, discarded sense bits
      wr(8'h68, 32'h31);
      rd_lit(8'h68, 32'h11, "R2 readback");
      src_i[40] = 1'b1; step(2); pins(0, 0, "R2 low-active idle");
      src_i[40] = 1'b0; step(1); pins(1, 0, "R2 low-active asserted");

      // R6 vectors, lowest slot wins
      wr(8'h85, 32'h123400A8);
      rd_lit(8'h06, 32'h1234, "R6 single slot");
      wr(8'h69, 32'h01);
      wr(8'h82, 32'hBEEF00A9);
      src_i[41] = 1'b1; step(1);
      rd_lit(8'h06, 32'hBEEF, "R6 lower slot wins");
      src_i[41] = 1'b0; step(1);
      rd_lit(8'h06, 32'h1234, "R6 back to higher slot");

      // R7 mask
      wr(8'h0A, 32'h203); step(2);
      pins(0, 0, "R7 slot 5 at mask 3");
      rd_lit(8'h06, 32'h0, "R6 default when masked");
      wr(8'h08, 32'h0F0F);
      rd_lit(8'h06, 32'h0F0F, "R6 programmed default");
      wr(8'h0A, 32'h206); step(2);
      pins(1, 0, "R7 slot 5 at mask 6");
      wr(8'h0A, 32'h205); step(2);
      pins(0, 0, "R7 slot 5 at mask 5");
      src_i[40] = 1'b1;
      wr(8'h6A, 32'h01);
      src_i[42] = 1'b1;
      wr(8'h0A, 32'h220); step(2);
      pins(0, 0, "R7 unbound at mask 32");
      wr(8'h0A, 32'h221); step(2);
      pins(1, 0, "R7 unbound at mask 33");
      src_i[42] = 1'b0; step(2);

      // R1 / R8 fast path
      wr(8'h09, 32'h00BB00AA);
      wr(8'h6B, 32'h07);
      src_i[43] = 1'b1; step(2);
      pins(0, 1, "R1 steered to fast path");
      rd_lit(8'h07, 32'hBB, "R8 low-level vector");
      wr(8'h6C, 32'h03);
      src_i[44] = 1'b1; step(1);
      rd_lit(8'h07, 32'hAA, "R8 high level wins");
      wr(8'h0A, 32'h121);
      src_i[44] = 1'b0; step(2);
      pins(0, 0, "R8 low level masked");
      rd_lit(8'h07, 32'h0, "R8 no fast vector");
      wr(8'h0A, 32'h221); step(2);
      pins(0, 1, "R8 low level unmasked");
      src_i[43] = 1'b0; step(2);
      wr(8'h6D, 32'h02);
      src_i[45] = 1'b1; step(2);
      pins(0, 0, "R1 disabled source quiet");
      src_i[45] = 1'b0;

      // R3 external level timing
      wr(8'h43, 32'h01);
      src_i[3] = 1'b1;
      step(1); pins(0, 0, "R3 edge 1");
      step(1); pins(0, 0, "R3 edge 2");
      step(1); pins(1, 0, "R3 edge 3");
      src_i[3] = 1'b0; step(4);
      pins(0, 0, "R3 level released");
      src_i[4] = 1'b0;
      wr(8'h44, 32'h11); step(4);
      pins(1, 0, "R3 low level active");
      src_i[4] = 1'b1; step(4);
      pins(0, 0, "R3 low level idle");

      // R3 / R4 rising edge, sticky, clear
      wr(8'h40, 32'h21);
      src_i[0] = 1'b1; step(1); src_i[0] = 1'b0;
      step(2); pins(0, 0, "R3 edge not yet");
      step(1); pins(1, 0, "R3 edge at fourth");
      step(4); pins(1, 0, "R4 sticky after pulse");
      rd_lit(8'h00, 32'h1, "R9 raw word");
      rd_lit(8'h02, 32'h1, "R9 masked word");
      wr(8'h04, 32'h1); step(1);
      pins(0, 0, "R4 cleared");
      rd_lit(8'h00, 32'h0, "R4 raw after clear");

      // R4 falling edge
      wr(8'h41, 32'h31);
      src_i[1] = 1'b1; step(5); pins(0, 0, "R4 falling ignores rise");
      src_i[1] = 1'b0; step(5); pins(1, 0, "R4 falling caught");
      wr(8'h04, 32'h2); step(1); pins(0, 0, "R4 falling cleared");

      // R4 either edge
      wr(8'h42, 32'h41);
      src_i[2] = 1'b1; step(5); pins(1, 0, "R4 both: rise");
      wr(8'h04, 32'h4); step(1); pins(0, 0, "R4 both cleared");
      src_i[2] = 1'b0; step(5); pins(1, 0, "R4 both: fall");
      wr(8'h04, 32'h4); step(1);

      // R4 switching to level drops pending
      src_i[0] = 1'b1; step(1); src_i[0] = 1'b0; step(5);
      pins(1, 0, "R4 pending again");
      wr(8'h40, 32'h01); step(1);
      pins(0, 0, "R4 level mode drops pending");

      // R9 raw vs delivered
      wr(8'h6E, 32'h00);
      src_i[46] = 1'b1; step(1);
      rd_lit(8'h01, 32'h4000, "R9 raw includes disabled");
      rd_lit(8'h03, 32'h0, "R9 masked excludes disabled");
      src_i[46] = 1'b0;
      for (int a = 0; a < 11; a++) rd_lit(8'(a), m_read(8'(a)), "R9 sweep");

      step(2);
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule